// File: doc/BRIEF.md
# Remap Register Binding Unit

This control block carries out the setup step for index-driven element remapping. Each request names a set of operand slots and a description of an index table: the register that holds the table, the size of its first dimension, whether the two dimensions are traversed in swapped order, whether a dimension is skipped, and the element width of the indices. The block turns that description into a 32-bit shape word and writes it into a bank of four shape registers. It also updates the remap binding state: one 2-bit shape selector per operand slot, a 5-bit enable mask and a persistence flag.

Two request modes exist. In allocation mode the binding state is wiped and every enabled slot receives the next shape register in turn, wrapping after the fourth. In targeted mode exactly one slot and one shape register are named, only those are updated, and persistence is switched on. The work is sequenced over several cycles, one slot per cycle, and a one-cycle done pulse marks the end. Requests that arrive while the block is busy are dropped.

Top module: `remap_bind_unit`

## Requirements
- R1: After reset all four shape words, all selectors, the enable mask, the persistence flag, busy and done are zero.
- R2: A shape word holds, from bit 0 upward: the first-dimension code [5:0], the second-dimension code [11:6], the index register number [18:12] (request field shifted left by two, low two bits zero), the order code [21:19] (111 when the swapped-order bit is 1, else 110), the skip bit [22], the element-width code [24:23], and zero in [31:25].
- R3: Dimension codes are stored one below the size, so codes 0..31 mean 1..32; the first-dimension code is the request's dimension field.
- R4: When swapped order is 1 and skip is 0, the second dimension is ceil(MAXVL / first dimension), with MAXVL 0 treated as 1 and the result capped at 64; otherwise the second dimension is 1 (code 0).
- R5: An allocation request (mode 0) clears all four shape words and all selectors before any slot is written; slots whose mask bit is clear end with selector 0, and shape registers not allocated end as zero.
- R6: In mode 0 mask bit i enables slot i (slot 0 to 4: source A, source B, source C, result 0, result 1); slots are visited from bit 0 to bit 4, and each enabled slot gets the next shape register, counting from 0 and wrapping modulo 4, which is written with the request's shape word.
- R7: In mode 0 the enable mask becomes the request mask and persistence becomes 0.
- R8: A targeted request (mode 1) uses mask bits [4:2] as the slot number and bits [1:0] as the shape number; it writes that shape word, sets that slot's selector to the shape number and its enable bit to 1, sets persistence to 1, and leaves every other shape, selector and enable bit unchanged; slot numbers 5 to 7 write only the shape word and persistence.
- R9: A request is accepted on a clock edge where it is valid and busy is low; busy is high from the next cycle; done is high for exactly one cycle, 5 cycles after acceptance in mode 0 and 1 cycle after in mode 1, with busy already low.
- R10: Requests presented while busy is high are ignored, and no output state changes unless a request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| mask_mode_i | input | 1 | 0 allocation, 1 targeted |
| mask_i | input | 5 | Slot mask, or slot and shape number |
| idx_base_i | input | 5 | Index register field |
| dim_i | input | 5 | First-dimension size minus one |
| order2d_i | input | 1 | Swapped traversal order |
| skip_i | input | 1 | Skip-dimension bit |
| elw_i | input | 2 | Index element-width code |
| maxvl_i | input | 7 | Current maximum vector length |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| shapes_o | output | 128 | Four shape words, shape n at bits [32n+31:32n] |
| sel_o | output | 10 | Slot selectors, slot i at bits [2i+1:2i] |
| en_o | output | 5 | Slot enable mask |
| persist_o | output | 1 | Persistence flag |

## Verification
The bench walks every 5-bit mask in both modes, so wrap-around with all five slots enabled, the empty mask and slot codes 5 to 7 are all visited; a design that failed to wrap, forgot to clear stale selectors or wrote an out-of-range slot would leave a wrong selector or shape word behind. A dimension sweep against several MAXVL values, including 0, exact multiples and 127, catches a floor where a ceiling belongs, a missing off-by-one, or an overflowing second-dimension field. A request injected mid-walk must leave no trace, which exposes a sequencer that restarts or re-latches while busy, and done is timed to the exact cycle in each mode.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  localparam int SHAPE_W   = 32;
  localparam int DIM_FW    = 6;
  localparam int REG_FW    = 7;
  localparam int IDXREG_W  = 5;
  localparam int ELW_W     = 2;
  localparam int OFFS_W    = 7;
  localparam int Y_LIMIT   = 1 << DIM_FW;

  typedef struct packed {
    logic [OFFS_W-1:0]  offs;
    logic [ELW_W-1:0]   elw;
    logic               skip;
    logic [2:0]         order;
    logic [REG_FW-1:0]  base;
    logic [DIM_FW-1:0]  ysz;
    logic [DIM_FW-1:0]  xsz;
  } shape_t;

  localparam logic [2:0] ORDER_XY = 3'b110;
  localparam logic [2:0] ORDER_YX = 3'b111;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WALK = 1'b1
  } seq_state_t;

endpackage

// File: rtl/rbu_shape_fmt.sv
module rbu_shape_fmt
  import rbu_pkg::*;
#(
  parameter int MAXVL_W = 7
) (
  input  logic [IDXREG_W-1:0] base_i,
  input  logic [4:0]          dim_i,
  input  logic                order2d_i,
  input  logic                skip_i,
  input  logic [ELW_W-1:0]    elw_i,
  input  logic [MAXVL_W-1:0]  maxvl_i,
  output logic [SHAPE_W-1:0]  word_o
);

  localparam int NW = MAXVL_W + 2;

  logic [NW-1:0] mv_eff;
  logic [NW-1:0] divisor;
  logic [NW-1:0] numer;
  logic [NW-1:0] quot;
  logic [NW-1:0] ydim;
  shape_t        shp;

  always_comb begin
    mv_eff  = (maxvl_i == '0) ? NW'(1) : NW'(maxvl_i);
    divisor = NW'(dim_i) + NW'(1);
    numer   = mv_eff + divisor - NW'(1);
    quot    = numer / divisor;
    if (quot > NW'(Y_LIMIT)) begin
      ydim = NW'(Y_LIMIT);
    end else begin
      ydim = quot;
    end

    shp.offs  = '0;
    shp.elw   = elw_i;
    shp.skip  = skip_i;
    shp.order = order2d_i ? ORDER_YX : ORDER_XY;
    shp.base  = {base_i, 2'b00};
    shp.xsz   = DIM_FW'(dim_i);
    if (order2d_i && !skip_i) begin
      shp.ysz = DIM_FW'(ydim - NW'(1));
    end else begin
      shp.ysz = '0;
    end
    word_o = shp;
  end

endmodule

// File: rtl/rbu_seq.sv
module rbu_seq
  import rbu_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             mode_i,
  output logic             accept_o,
  output logic             step_o,
  output logic [IDX_W-1:0] step_idx_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_state_t       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             mode_q, mode_n;
  logic             done_q, done_n;
  logic             last;

  assign accept_o   = req_valid_i && (state_q == SEQ_IDLE);
  assign step_o     = (state_q == SEQ_WALK);
  assign step_idx_o = idx_q;
  assign busy_o     = (state_q == SEQ_WALK);
  assign done_o     = done_q;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    mode_n  = mode_q;
    done_n  = 1'b0;
    last    = mode_q || (idx_q == IDX_W'(NUM_SLOTS - 1));
    if (accept_o) begin
      state_n = SEQ_WALK;
      idx_n   = '0;
      mode_n  = mode_i;
    end else if (step_o) begin
      if (last) begin
        state_n = SEQ_IDLE;
        done_n  = 1'b1;
      end else begin
        idx_n = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      mode_q  <= mode_n;
      done_q  <= done_n;
    end
  end

endmodule

// File: rtl/rbu_shape_bank.sv
module rbu_shape_bank
  import rbu_pkg::*;
#(
  parameter int NUM_SHAPES = 4,
  localparam int SEL_W     = $clog2(NUM_SHAPES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_sel_i,
  input  logic [SHAPE_W-1:0]            wr_data_i,
  output logic [NUM_SHAPES*SHAPE_W-1:0] shapes_o
);

  for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_entry
    logic [SHAPE_W-1:0] word_q, word_n;
    logic               ce;

    always_comb begin
      ce     = clr_i || (wr_en_i && (wr_sel_i == SEL_W'(g)));
      word_n = clr_i ? '0 : wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (ce) begin
        word_q <= word_n;
      end
    end

    assign shapes_o[g*SHAPE_W +: SHAPE_W] = word_q;
  end

endmodule

// File: rtl/remap_bind_unit.sv
module remap_bind_unit
  import rbu_pkg::*;
#(
  parameter int NUM_SHAPES = 4,
  parameter int NUM_SLOTS  = 5,
  parameter int MAXVL_W    = 7,
  localparam int SEL_W     = $clog2(NUM_SHAPES),
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int SLOT_FW   = NUM_SLOTS - SEL_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid_i,
  input  logic                          mask_mode_i,
  input  logic [NUM_SLOTS-1:0]          mask_i,
  input  logic [IDXREG_W-1:0]           idx_base_i,
  input  logic [4:0]                    dim_i,
  input  logic                          order2d_i,
  input  logic                          skip_i,
  input  logic [ELW_W-1:0]              elw_i,
  input  logic [MAXVL_W-1:0]            maxvl_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [NUM_SHAPES*SHAPE_W-1:0] shapes_o,
  output logic [NUM_SLOTS*SEL_W-1:0]    sel_o,
  output logic [NUM_SLOTS-1:0]          en_o,
  output logic                          persist_o
);

  logic             accept;
  logic             step;
  logic [IDX_W-1:0] step_idx;

  // latched request
  logic [NUM_SLOTS-1:0]  op_mask_q;
  logic                  op_mode_q;
  logic [IDXREG_W-1:0]   op_base_q;
  logic [4:0]            op_dim_q;
  logic                  op_ord_q;
  logic                  op_skip_q;
  logic [ELW_W-1:0]      op_elw_q;
  logic [MAXVL_W-1:0]    op_mv_q;

  // binding state
  logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_q, sel_n;
  logic [NUM_SLOTS-1:0]            en_q, en_n;
  logic                            pers_q, pers_n;
  logic [SEL_W-1:0]                ptr_q, ptr_n;
  logic                            state_ce;

  logic                  bank_clr;
  logic                  bank_we;
  logic [SEL_W-1:0]      bank_sel;
  logic [SHAPE_W-1:0]    shape_word;
  logic [SLOT_FW-1:0]    tgt_slot;
  logic [SEL_W-1:0]      tgt_shape;

  rbu_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .mode_i     (mask_mode_i),
    .accept_o   (accept),
    .step_o     (step),
    .step_idx_o (step_idx),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  rbu_shape_fmt #(.MAXVL_W(MAXVL_W)) u_fmt (
    .base_i   (op_base_q),
    .dim_i    (op_dim_q),
    .order2d_i(op_ord_q),
    .skip_i   (op_skip_q),
    .elw_i    (op_elw_q),
    .maxvl_i  (op_mv_q),
    .word_o   (shape_word)
  );

  rbu_shape_bank #(.NUM_SHAPES(NUM_SHAPES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (bank_clr),
    .wr_en_i  (bank_we),
    .wr_sel_i (bank_sel),
    .wr_data_i(shape_word),
    .shapes_o (shapes_o)
  );

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mask_q <= '0;
      op_mode_q <= 1'b0;
      op_base_q <= '0;
      op_dim_q  <= '0;
      op_ord_q  <= 1'b0;
      op_skip_q <= 1'b0;
      op_elw_q  <= '0;
      op_mv_q   <= '0;
    end else if (accept) begin
      op_mask_q <= mask_i;
      op_mode_q <= mask_mode_i;
      op_base_q <= idx_base_i;
      op_dim_q  <= dim_i;
      op_ord_q  <= order2d_i;
      op_skip_q <= skip_i;
      op_elw_q  <= elw_i;
      op_mv_q   <= maxvl_i;
    end
  end

  assign tgt_slot  = op_mask_q[NUM_SLOTS-1:SEL_W];
  assign tgt_shape = op_mask_q[SEL_W-1:0];

  // next binding state
  always_comb begin
    sel_n    = sel_q;
    en_n     = en_q;
    pers_n   = pers_q;
    ptr_n    = ptr_q;
    bank_clr = 1'b0;
    bank_we  = 1'b0;
    bank_sel = '0;
    if (accept && !mask_mode_i) begin
      bank_clr = 1'b1;
      sel_n    = '0;
      en_n     = mask_i;
      pers_n   = 1'b0;
      ptr_n    = '0;
    end else if (step) begin
      if (!op_mode_q) begin
        if (op_mask_q[step_idx]) begin
          bank_we         = 1'b1;
          bank_sel        = ptr_q;
          sel_n[step_idx] = ptr_q;
          ptr_n           = ptr_q + SEL_W'(1);
        end
      end else begin
        bank_we  = 1'b1;
        bank_sel = tgt_shape;
        pers_n   = 1'b1;
        if (int'(tgt_slot) < NUM_SLOTS) begin
          sel_n[IDX_W'(tgt_slot)] = tgt_shape;
          en_n[IDX_W'(tgt_slot)]  = 1'b1;
        end
      end
    end
  end

  assign state_ce = accept || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= '0;
      pers_q <= 1'b0;
      ptr_q  <= '0;
    end else if (state_ce) begin
      sel_q  <= sel_n;
      en_q   <= en_n;
      pers_q <= pers_n;
      ptr_q  <= ptr_n;
    end
  end

  assign sel_o     = sel_q;
  assign en_o      = en_q;
  assign persist_o = pers_q;

endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
  parameter int NUM_SHAPES = 4,
  parameter int NUM_SLOTS  = 5,
  parameter int SHAPE_W    = 32,
  localparam int SEL_W     = $clog2(NUM_SHAPES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid_i,
  input logic                          mask_mode_i,
  input logic [NUM_SLOTS-1:0]          mask_i,
  input logic                          busy_o,
  input logic                          done_o,
  input logic [NUM_SHAPES*SHAPE_W-1:0] shapes_o,
  input logic [NUM_SLOTS*SEL_W-1:0]    sel_o,
  input logic [NUM_SLOTS-1:0]          en_o,
  input logic                          persist_o
);

  logic                 acc_mode_q;
  logic [NUM_SLOTS-1:0] acc_mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_mode_q <= 1'b0;
      acc_mask_q <= '0;
    end else if (req_valid_i && !busy_o) begin
      acc_mode_q <= mask_mode_i;
      acc_mask_q <= mask_i;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !busy_o) |=> busy_o);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !req_valid_i) |=> ($stable(shapes_o) && $stable(sel_o)
                                   && $stable(en_o) && $stable(persist_o)));

  assert_alloc_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !acc_mode_q) |-> (en_o == acc_mask_q && !persist_o));

  assert_target_persist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && acc_mode_q) |-> persist_o);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assert_unused_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !acc_mode_q && !acc_mask_q[s]) |-> (sel_o[s*SEL_W +: SEL_W] == '0));
  end

endmodule

bind remap_bind_unit rbu_checker #(
  .NUM_SHAPES(NUM_SHAPES),
  .NUM_SLOTS (NUM_SLOTS),
  .SHAPE_W   (rbu_pkg::SHAPE_W)
) u_rbu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .mask_mode_i(mask_mode_i),
  .mask_i     (mask_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .shapes_o   (shapes_o),
  .sel_o      (sel_o),
  .en_o       (en_o),
  .persist_o  (persist_o)
);

// File: tb/tb_remap_bind_unit.sv
module tb_remap_bind_unit;

  logic         clk;
  logic         rst_n;
  logic         req_valid_i;
  logic         mask_mode_i;
  logic [4:0]   mask_i;
  logic [4:0]   idx_base_i;
  logic [4:0]   dim_i;
  logic         order2d_i;
  logic         skip_i;
  logic [1:0]   elw_i;
  logic [6:0]   maxvl_i;
  logic         busy_o;
  logic         done_o;
  logic [127:0] shapes_o;
  logic [9:0]   sel_o;
  logic [4:0]   en_o;
  logic         persist_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] exp_shape [4];
  logic [1:0]  exp_sel   [5];
  logic [4:0]  exp_en;
  logic        exp_pers;

  remap_bind_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .mask_mode_i(mask_mode_i),
    .mask_i(mask_i), .idx_base_i(idx_base_i), .dim_i(dim_i), .order2d_i(order2d_i),
    .skip_i(skip_i), .elw_i(elw_i), .maxvl_i(maxvl_i), .busy_o(busy_o),
    .done_o(done_o), .shapes_o(shapes_o), .sel_o(sel_o), .en_o(en_o),
    .persist_o(persist_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // R2, R3, R4: expected shape word from the request fields
  function automatic logic [31:0] shape_word(input logic [4:0] base, input logic [4:0] dim,
      input logic ord, input logic skp, input logic [1:0] elw, input logic [6:0] mv);
    int mve;
    int y;
    logic [5:0] ycode;
    mve = (mv == 0) ? 1 : int'(mv);
    y = 1;
    while (y * (int'(dim) + 1) < mve) y++;
    if (y > 64) y = 64;
    ycode = (ord && !skp) ? 6'(y - 1) : 6'd0;
    return {7'd0, elw, skp, (ord ? 3'b111 : 3'b110), base, 2'b00, ycode, 1'b0, dim};
  endfunction

  task automatic compare_state(input string tag);
    for (int s = 0; s < 4; s++) check({tag, " shape"}, shapes_o[s*32 +: 32], exp_shape[s]);
    for (int i = 0; i < 5; i++) check({tag, " sel"}, 32'(sel_o[i*2 +: 2]), 32'(exp_sel[i]));
    check({tag, " en"}, 32'(en_o), 32'(exp_en));
    check({tag, " persist"}, 32'(persist_o), 32'(exp_pers));
  endtask

  task automatic run_req(input logic mode, input logic [4:0] mask, input logic [4:0] base,
      input logic [4:0] dim, input logic ord, input logic skp, input logic [1:0] elw,
      input logic [6:0] mv, input bit interfere, input string tag);
    logic [31:0] w;
    int ptr;
    int nwait;
    w = shape_word(base, dim, ord, skp, elw, mv);
    if (!mode) begin
      // R5, R6, R7
      for (int s = 0; s < 4; s++) exp_shape[s] = '0;
      for (int i = 0; i < 5; i++) exp_sel[i] = '0;
      ptr = 0;
      for (int i = 0; i < 5; i++) begin
        if (mask[i]) begin
          exp_shape[ptr] = w;
          exp_sel[i] = 2'(ptr);
          ptr = (ptr + 1) % 4;
        end
      end
      exp_en = mask;
      exp_pers = 1'b0;
    end else begin
      // R8
      exp_shape[mask[1:0]] = w;
      if (mask[4:2] < 3'd5) begin
        exp_sel[mask[4:2]] = mask[1:0];
        exp_en[mask[4:2]] = 1'b1;
      end
      exp_pers = 1'b1;
    end
    @(negedge clk);
    req_valid_i = 1'b1; mask_mode_i = mode; mask_i = mask; idx_base_i = base;
    dim_i = dim; order2d_i = ord; skip_i = skp; elw_i = elw; maxvl_i = mv;
    @(negedge clk);
    req_valid_i = 1'b0;
    check({tag, " R9 busy after accept"}, 32'(busy_o), 32'd1);
    nwait = mode ? 1 : 5;
    for (int k = 1; k <= nwait; k++) begin
      if (interfere && k == 1) begin
        // R10: request while busy must be dropped
        req_valid_i = 1'b1; mask_mode_i = ~mode; mask_i = ~mask; idx_base_i = ~base;
        dim_i = ~dim; order2d_i = ~ord; skip_i = ~skp; elw_i = ~elw; maxvl_i = ~mv;
      end
      @(negedge clk);
      req_valid_i = 1'b0;
      if (k < nwait) begin
        if (done_o !== 1'b0 || busy_o !== 1'b1) begin
          check({tag, " R9 early done/busy"}, {30'd0, done_o, busy_o}, 32'd1);
        end
      end else begin
        check({tag, " R9 done"}, 32'(done_o), 32'd1);
        check({tag, " R9 busy at done"}, 32'(busy_o), 32'd0);
      end
    end
    @(negedge clk);
    check({tag, " R9 done one cycle"}, 32'(done_o), 32'd0);
    compare_state(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0; mask_mode_i = 1'b0; mask_i = '0; idx_base_i = '0;
    dim_i = '0; order2d_i = 1'b0; skip_i = 1'b0; elw_i = '0; maxvl_i = '0;
    for (int s = 0; s < 4; s++) exp_shape[s] = '0;
    for (int i = 0; i < 5; i++) exp_sel[i] = '0;
    exp_en = '0;
    exp_pers = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_state("R1 reset");
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);

    // R5 R6 R7: allocation over every mask
    for (int m = 0; m < 32; m++) begin
      run_req(1'b0, 5'(m), 5'(m ^ 21), 5'((m * 7) % 32), m[0], m[1] & m[2],
              2'(m >> 3), 7'((m * 13) % 128), 1'b0, "R6 alloc");
    end

    // R8: targeted updates over every mask, cumulative
    for (int m = 0; m < 32; m++) begin
      run_req(1'b1, 5'(m), 5'(31 - m), 5'((m * 5) % 32), m[1], m[3],
              2'(m), 7'((m * 29 + 3) % 128), 1'b0, "R8 target");
    end

    // R3 R4: second-dimension arithmetic
    for (int d = 0; d < 32; d++) begin
      for (int v = 0; v < 6; v++) begin
        int mv;
        mv = (v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 31 : (v == 3) ? 64
           : (v == 4) ? 127 : (d + 1) * 3;
        run_req(1'b1, 5'b00000, 5'(d), 5'(d), 1'b1, 1'b0, 2'b01, 7'(mv), 1'b0, "R4 ydim");
      end
      run_req(1'b1, 5'b00101, 5'(d), 5'(d), 1'b1, 1'b1, 2'b10, 7'd100, 1'b0, "R4 skip");
      run_req(1'b1, 5'b01010, 5'(d), 5'(d), 1'b0, 1'b0, 2'b11, 7'd100, 1'b0, "R2 order");
    end

    // R10: request during a walk is ignored
    run_req(1'b0, 5'b10110, 5'd9, 5'd3, 1'b1, 1'b0, 2'b01, 7'd20, 1'b1, "R10 busy");
    run_req(1'b0, 5'b11111, 5'd1, 5'd7, 1'b0, 1'b0, 2'b00, 7'd50, 1'b1, "R10 busy wrap");
    repeat (3) begin
      @(negedge clk);
      check("R10 no stray done", 32'(done_o), 32'd0);
    end
    compare_state("R10 idle hold");

    // R5: empty allocation wipes everything
    run_req(1'b0, 5'b00000, 5'd4, 5'd4, 1'b1, 1'b0, 2'b00, 7'd9, 1'b0, "R5 clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule